// File: doc/BRIEF.md
# MAC Control and Status Register Block

This block holds the software-visible control state of an Ethernet MAC. It provides a word-addressed register port with 32-bit data, which firmware uses to program the engine enables, the descriptor list bases, the FIFO threshold and the receive frame limit. The transmit and receive engines read their settings from dedicated output pins. Each engine reports events back through one-cycle set pulses into a shared interrupt status word. Transmit events occupy the upper half of that word and receive events the lower half. Each half, masked by the matching half of the enable register, drives its own interrupt line.

A write of 1 to control bit 24 starts a self-timed software reset. For a fixed window of cycles, every register read returns zero and `engine_reset` holds both engines quiet. At the end of the window the whole block is back at its reset values. Firmware polls any register that resets to a non-zero value, such as the threshold register, to learn when the window has ended. The current descriptor and buffer pointers are loaded only by the engines. The bus can read them but cannot write them.

The register port has no handshake. A write takes effect at the clock edge where `reg_sel` and `reg_wr` are both high. Read data is combinational from `reg_addr`. No stream interface is present, and no back-pressure exists.

Top module: `mac_ctl_regs`

## Requirements
- R1: After `rst_n`, the registers read as follows:
  - 0x0 control = 0, 0x1 enable = 0, 0x2 status = 0
  - 0x3 and 0x4 list bases = 0xFFFFFFFC
  - 0x5 threshold = 0x0101, 0x6 frame limit = 0x0800
  - 0x7 management address = 0x00900000, 0x8 missed count = 0x7FFF
  - 0x9 to 0xC pointers = 0
- R2: Only certain bits accept writes:
  - Control: bits 0, 1 and 8.
  - Enable and management address: all 32 bits.
  - List bases: bits [31:2], with bits [1:0] reading 0.
  - Threshold, frame limit and missed count: bits [15:0].
  - All other bits read 0.
- R3: A bus write to status (0x2) clears each bit written as 1 and leaves the others unchanged. A bit of `sts_set` sets the matching status bit at the next edge.
- R4: When a set pulse and a write-1 clear hit the same status bit at the same edge, the bit ends up set.
- R5: `tx_irq` is the OR of status[31:16] AND enable[31:16]. `rx_irq` is the OR of status[15:0] AND enable[15:0].
- R6: A write with control bit 24 set starts a software-reset window. The window covers exactly 16 cycles after that edge. During the window every read returns 0. Afterwards all registers hold their R1 values, and control bit 24 reads 0.
- R7: `engine_reset` is 1 exactly during the window. `tx_enable` and `rx_enable` are 0 throughout it.
- R8: During the window, the block ignores bus writes (a repeated bit-24 write among them), status set pulses and pointer loads.
- R9: The pointer registers are 0x9 (tx descriptor), 0xA (tx buffer), 0xB (rx descriptor) and 0xC (rx buffer). Each loads `ptr_val` at an edge where `ptr_ld[j]` is high, where j = 0..3 maps to 0x9..0xC. Bus writes to them have no effect.
- R10: `tx_enable` follows control bit 8, `rx_enable` follows bit 0 and `long_frame_ok` follows bit 1. The list base, threshold and frame limit outputs follow their registers.
- R11: Addresses 0xD to 0xF read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sts_set | input | 32 | Status set pulses from the engines |
| ptr_ld | input | 4 | Pointer load strobes, one per pointer |
| ptr_val | input | 32 | Pointer value to load |
| tx_enable | output | 1 | Transmit engine on |
| rx_enable | output | 1 | Receive engine on |
| long_frame_ok | output | 1 | Accept over-length frames |
| tx_list_base | output | 32 | Transmit descriptor list base |
| rx_list_base | output | 32 | Receive descriptor list base |
| fifo_thresh | output | 16 | FIFO threshold setting |
| rx_max_len | output | 16 | Receive frame limit |
| engine_reset | output | 1 | Engines held in reset during the soft-reset window |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Several properties hold on every cycle and are checked by assertions:
- Reads are zero inside the soft-reset window.
- The window lasts exactly 16 cycles, and the list base has returned to its reset value when it closes.
- The engines stay disabled while `engine_reset` is high.
- A write-1 clear empties the bits it targets, while a coincident set pulse survives it.

Other behaviour is shown only by the bench's scenarios:
- The per-register write masks and reset values.
- The mapping of interrupt lines to enabled status halves.
- Pointer loading, together with the bus's inability to write the pointers.
- The requirement that writes, set pulses and loads arriving inside the window leave no trace.

// File: rtl/mac_ctl_regs_pkg.sv
package mac_ctl_regs_pkg;
  localparam int DW = 32;

  localparam int A_CTRL   = 0;
  localparam int A_IEN    = 1;
  localparam int A_ISTAT  = 2;
  localparam int A_TXBASE = 3;
  localparam int A_RXBASE = 4;
  localparam int A_FTHR   = 5;
  localparam int A_RXMAX  = 6;
  localparam int A_MGMT   = 7;
  localparam int A_MISS   = 8;
  localparam int A_PTR0   = 9;
  localparam int NUM_PTR  = 4;
  localparam int NUM_FLD  = 9;

  localparam int B_RXON = 0;
  localparam int B_LONG = 1;
  localparam int B_TXON = 8;
  localparam int B_SWR  = 24;

  function automatic logic [DW-1:0] fld_reset(input int idx);
    case (idx)
      A_TXBASE, A_RXBASE: fld_reset = 32'hFFFF_FFFC;
      A_FTHR:             fld_reset = 32'h0000_0101;
      A_RXMAX:            fld_reset = 32'h0000_0800;
      A_MGMT:             fld_reset = 32'h0090_0000;
      A_MISS:             fld_reset = 32'h0000_7FFF;
      default:            fld_reset = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] fld_mask(input int idx);
    case (idx)
      A_CTRL:                  fld_mask = (32'd1 << B_RXON) | (32'd1 << B_LONG) | (32'd1 << B_TXON);
      A_IEN, A_MGMT:           fld_mask = 32'hFFFF_FFFF;
      A_TXBASE, A_RXBASE:      fld_mask = 32'hFFFF_FFFC;
      A_FTHR, A_RXMAX, A_MISS: fld_mask = 32'h0000_FFFF;
      default:                 fld_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/ctl_swrst.sv
module ctl_swrst #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= LAST;
    end
  end
endmodule

// File: rtl/ctl_field_reg.sv
module ctl_field_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST;
    else if (clr) q <= RST;
    else if (we)  q <= d & MASK;
  end
endmodule

// File: rtl/ctl_irq.sv
module ctl_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] en,
  output logic [W-1:0] stat,
  output logic         tx_irq,
  output logic         rx_irq
);
  localparam int HALF = W / 2;

  logic [W-1:0] wipe;
  logic [1:0]   line;

  assign wipe = wr_stat ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (clr) stat <= '0;
    else          stat <= (stat & ~wipe) | set_in;
  end

  // group 0 = receive half, group 1 = transmit half
  for (genvar g = 0; g < 2; g++) begin : g_half
    assign line[g] = |(stat[g*HALF +: HALF] & en[g*HALF +: HALF]);
  end

  assign rx_irq = line[0];
  assign tx_irq = line[1];
endmodule

// File: rtl/mac_ctl_regs.sv
module mac_ctl_regs
  import mac_ctl_regs_pkg::*;
#(
  parameter int AW         = 4,
  parameter int SWR_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   sts_set,
  input  logic [3:0]    ptr_ld,
  input  logic [31:0]   ptr_val,
  output logic          tx_enable,
  output logic          rx_enable,
  output logic          long_frame_ok,
  output logic [31:0]   tx_list_base,
  output logic [31:0]   rx_list_base,
  output logic [15:0]   fifo_thresh,
  output logic [15:0]   rx_max_len,
  output logic          engine_reset,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int NREG = 1 << AW;

  logic            swr_busy;
  logic            swr_start;
  logic            clr;
  logic            wr_acc;
  logic [NREG-1:0] wsel;
  logic [DW-1:0]   istat;
  logic [DW-1:0]   rv [NREG];

  assign wr_acc = reg_sel & reg_wr & ~swr_busy;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wsel[i] = wr_acc && (reg_addr == AW'(i));
  end

  assign swr_start = wsel[A_CTRL] & reg_wdata[B_SWR];
  assign clr       = swr_start | swr_busy;

  ctl_swrst #(.CYCLES(SWR_CYCLES)) u_swr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (swr_start),
    .busy  (swr_busy)
  );

  ctl_irq #(.W(DW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_stat (wsel[A_ISTAT]),
    .wdata   (reg_wdata),
    .set_in  (sts_set),
    .en      (rv[A_IEN]),
    .stat    (istat),
    .tx_irq  (tx_irq),
    .rx_irq  (rx_irq)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == A_ISTAT) begin : g_stat
      assign rv[i] = istat;
    end else if (i < NUM_FLD) begin : g_fld
      logic [DW-1:0] q;
      ctl_field_reg #(.W(DW), .RST(fld_reset(i)), .MASK(fld_mask(i))) u_fld (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .we    (wsel[i]),
        .d     (reg_wdata),
        .q     (q)
      );
      if (i == A_CTRL) begin : g_ctl
        assign rv[i] = q | (DW'(swr_busy) << B_SWR);
      end else begin : g_plain
        assign rv[i] = q;
      end
    end else if (i >= A_PTR0 && i < A_PTR0 + NUM_PTR) begin : g_ptr
      logic [DW-1:0] p;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 p <= '0;
        else if (clr)               p <= '0;
        else if (ptr_ld[i-A_PTR0])  p <= ptr_val;
      end
      assign rv[i] = p;
    end else begin : g_hole
      assign rv[i] = '0;
    end
  end

  assign reg_rdata     = swr_busy ? '0 : rv[reg_addr];
  assign tx_enable     = rv[A_CTRL][B_TXON];
  assign rx_enable     = rv[A_CTRL][B_RXON];
  assign long_frame_ok = rv[A_CTRL][B_LONG];
  assign tx_list_base  = rv[A_TXBASE];
  assign rx_list_base  = rv[A_RXBASE];
  assign fifo_thresh   = rv[A_FTHR][15:0];
  assign rx_max_len    = rv[A_RXMAX][15:0];
  assign engine_reset  = swr_busy;
endmodule

// File: rtl/mac_ctl_regs_chk.sv
module mac_ctl_regs_chk #(
  parameter int AW         = 4,
  parameter int SWR_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic [31:0]   sts_set,
  input logic          engine_reset,
  input logic          tx_enable,
  input logic          rx_enable,
  input logic [31:0]   tx_list_base,
  input logic          swr_busy,
  input logic [31:0]   istat
);
  localparam int CW = $clog2(SWR_CYCLES + 1) + 1;

  logic [CW-1:0] win_cnt;
  logic          stat_wr;
  logic          swr_wr;

  assign stat_wr = reg_sel && reg_wr && (reg_addr == AW'(2)) && !swr_busy;
  assign swr_wr  = reg_sel && reg_wr && (reg_addr == AW'(0)) && reg_wdata[24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_cnt <= '0;
    else if (swr_busy) win_cnt <= win_cnt + 1'b1;
    else               win_cnt <= '0;
  end

  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> reg_rdata == 32'd0);

  // R6
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> win_cnt < CW'(SWR_CYCLES));

  // R6
  win_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swr_busy) |-> win_cnt == CW'(SWR_CYCLES));

  // R1
  base_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swr_busy) |-> tx_list_base == 32'hFFFF_FFFC);

  // R7
  eng_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_reset |-> (!tx_enable && !rx_enable));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((istat & $past(reg_wdata) & ~$past(sts_set)) == 32'd0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!swr_busy && !swr_wr && (sts_set != 32'd0)) |=>
      ((istat & $past(sts_set)) == $past(sts_set)));
endmodule

bind mac_ctl_regs mac_ctl_regs_chk #(.AW(AW), .SWR_CYCLES(SWR_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_sel      (reg_sel),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .sts_set      (sts_set),
  .engine_reset (engine_reset),
  .tx_enable    (tx_enable),
  .rx_enable    (rx_enable),
  .tx_list_base (tx_list_base),
  .swr_busy     (swr_busy),
  .istat        (istat)
);

// File: tb/mac_ctl_regs_test.sv
module mac_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] sts_set = '0;
  logic [3:0]  ptr_ld = '0;
  logic [31:0] ptr_val = '0;
  logic        tx_enable, rx_enable, long_frame_ok;
  logic [31:0] tx_list_base, rx_list_base;
  logic [15:0] fifo_thresh, rx_max_len;
  logic        engine_reset, tx_irq, rx_irq;

  int total = 0;
  int fails = 0;
  logic [31:0] e [16];

  always #2 clk = ~clk;

  mac_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sts_set(sts_set), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .long_frame_ok(long_frame_ok),
    .tx_list_base(tx_list_base), .rx_list_base(rx_list_base),
    .fifo_thresh(fifo_thresh), .rx_max_len(rx_max_len),
    .engine_reset(engine_reset), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  function automatic logic [31:0] m_rst(input int a);
    case (a)
      3, 4:    return 32'hFFFF_FFFC;
      5:       return 32'h0000_0101;
      6:       return 32'h0000_0800;
      7:       return 32'h0090_0000;
      8:       return 32'h0000_7FFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_mask(input int a);
    case (a)
      0:       return 32'h0000_0103;
      1, 7:    return 32'hFFFF_FFFF;
      3, 4:    return 32'hFFFF_FFFC;
      5, 6, 8: return 32'h0000_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_tx_irq();
    return |(e[2][31:16] & e[1][31:16]);
  endfunction

  function automatic logic m_rx_irq();
    return |(e[2][15:0] & e[1][15:0]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int a);
    @(negedge clk);
    reg_sel = 1'b0; reg_addr = 4'(a);
    #1 chk(tag, reg_rdata, e[a]);
  endtask

  task automatic cycle(input logic wr, input int a, input logic [31:0] d,
                       input logic [31:0] set, input logic [3:0] ld, input logic [31:0] pv);
    @(negedge clk);
    reg_sel = wr; reg_wr = wr; reg_addr = 4'(a); reg_wdata = d;
    sts_set = set; ptr_ld = ld; ptr_val = pv;
    @(posedge clk);
    #1;
    if (wr && a == 2) e[2] = (e[2] & ~d) | set;
    else begin
      e[2] = e[2] | set;
      if (wr && a <= 8) e[a] = d & m_mask(a);
    end
    for (int j = 0; j < 4; j++) if (ld[j]) e[9+j] = pv;
    reg_sel = 0; reg_wr = 0; sts_set = '0; ptr_ld = '0;
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) e[i] = m_rst(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R11 holes read zero
    for (int i = 0; i < 13; i++) rd_chk($sformatf("R1 reset addr %0d", i), i);
    for (int i = 13; i < 16; i++) rd_chk($sformatf("R11 hole addr %0d", i), i);
    chk("R1 irq lines idle", {30'd0, tx_irq, rx_irq}, 32'd0);

    // R2 write masks; R9 pointer registers not bus-writable
    for (int i = 0; i < 13; i++) if (i != 2) cycle(1, i, 32'hFEFF_FFFF, 0, 0, 0);
    for (int i = 0; i < 13; i++) if (i != 2) rd_chk($sformatf("R2 mask addr %0d", i), i);
    rd_chk("R9 ptr bus write ignored", 10);

    // R10 exported settings
    @(negedge clk);
    chk("R10 enables", {29'd0, tx_enable, long_frame_ok, rx_enable}, 32'd7);
    chk("R10 tx base", tx_list_base, 32'hFEFF_FFFC);
    chk("R10 thresh/limit", {fifo_thresh, rx_max_len}, 32'hFFFF_FFFF);
    cycle(1, 0, 32'h0000_0100, 0, 0, 0);
    @(negedge clk);
    chk("R10 tx only", {29'd0, tx_enable, long_frame_ok, rx_enable}, 32'd4);
    cycle(1, 1, 32'h0, 0, 0, 0);

    // R3 set then write-1 clear
    cycle(0, 0, 0, 32'h0005_0011, 0, 0);
    rd_chk("R3 set pulses", 2);
    cycle(1, 2, 32'h0004_0001, 0, 0, 0);
    rd_chk("R3 w1c partial", 2);
    chk("R3 value", e[2], 32'h0001_0010);

    // R4 set wins over coincident clear
    cycle(1, 2, 32'hFFFF_FFFF, 32'h0001_0000, 0, 0);
    rd_chk("R4 set beats clear", 2);

    // R5 interrupt lines
    cycle(1, 1, 32'h0004_0010, 0, 0, 0);
    @(negedge clk);
    chk("R5 no enabled bits", {30'd0, tx_irq, rx_irq}, 32'd0);
    cycle(0, 0, 0, 32'h0004_0001, 0, 0);
    @(negedge clk);
    chk("R5 tx only", {30'd0, tx_irq, rx_irq}, 32'd2);
    cycle(0, 0, 0, 32'h0000_0010, 0, 0);
    @(negedge clk);
    chk("R5 both", {30'd0, tx_irq, rx_irq}, 32'd3);

    // R9 pointer loads
    cycle(0, 0, 0, 0, 4'b0101, 32'h1234_5678);
    cycle(0, 0, 0, 0, 4'b1000, 32'hCAFE_0004);
    for (int i = 9; i < 13; i++) rd_chk($sformatf("R9 ptr addr %0d", i), i);

    // Random phase: R2, R3, R4, R5, R9 against the model
    for (int n = 0; n < 400; n++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom_range(0, 15));
      d = $urandom();
      if (a == 0) d[24] = 1'b0;
      cycle($urandom_range(0, 1) == 1, a, d,
            ($urandom_range(0, 3) == 0) ? $urandom() : 32'd0,
            4'($urandom_range(0, 15)), $urandom());
      rd_chk($sformatf("R2 random rd addr %0d", a), a);
      chk("R5 random irq", {30'd0, tx_irq, rx_irq}, {30'd0, m_tx_irq(), m_rx_irq()});
    end

    // R6/R7/R8 soft reset window
    cycle(1, 1, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0);
    cycle(1, 0, 32'h0000_0103, 0, 0, 0);
    cycle(1, 0, 32'h0100_0103, 0, 0, 0);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      reg_sel = 0; reg_wr = 0; sts_set = '0; ptr_ld = '0; reg_addr = 4'd3;
      if (k == 3) begin reg_sel = 1; reg_wr = 1; reg_addr = 4'd1; reg_wdata = 32'hFFFF_FFFF; sts_set = 32'hFFFF_FFFF; end
      if (k == 5) begin ptr_ld = 4'hF; ptr_val = 32'hDEAD_BEE0; end
      if (k == 8) begin reg_sel = 1; reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h0100_0103; end
      #1;
      chk($sformatf("R6 read zero k=%0d", k), reg_rdata, 32'd0);
      chk($sformatf("R7 engines held k=%0d", k), {29'd0, engine_reset, tx_enable, rx_enable}, 32'd4);
    end
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; sts_set = '0; ptr_ld = '0;
    for (int i = 0; i < 16; i++) e[i] = m_rst(i);
    #1 chk("R6 window ends after 16", reg_rdata, 32'hFFFF_FFFC);
    chk("R7 engine_reset released", {31'd0, engine_reset}, 32'd0);
    for (int i = 0; i < 13; i++) rd_chk($sformatf("R8 after window addr %0d", i), i);
    chk("R8 no irq after window", {30'd0, tx_irq, rx_irq}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule